// File: doc/BRIEF.md
# Scan Test Mode Sequencer

This block runs scan test patterns on an internal chain of mux-D flops. The chain has a parameterised length, and the block drives the chain's scan-enable and gates its shift and capture clock enables. A test run starts on a pulse of `start_i` that carries the number of patterns. For each pattern the block first shifts in a stimulus. It then drops scan-enable and waits a programmable settle window with no clock enable active. Next it issues one capture pulse, or a launch pulse followed by a capture pulse. Finally it raises scan-enable again to shift the response out while the next stimulus shifts in.

Stimulus, expected response and an unknown-bit mask arrive serially, one bit per shift cycle. Each unloaded bit is compared with the expected value unless the mask flags it. The first failing pattern is recorded and the fail flag stays set. After the last pattern, a final unload-only pass drains the chain, and then `done_o` pulses for one cycle.

The functional logic between the chain flops is modelled inside the block: on a capture pulse, flop i loads q[i] XOR q[(i+1) mod N]. Flop 0 is the head and flop N-1 the tail.

Top module: `scan_seq_top`

## Requirements
- R1: While `se_o` is 1, each shift cycle moves every chain bit one position towards the tail: `stim_i` enters flop 0, and `scan_out_o` always shows flop N-1.
- R2: On a capture-enable cycle (`se_o` 0, `cap_en_o` 1), every flop i loads its functional input q[i] XOR q[(i+1) mod N].
- R3: After a start is accepted with a nonzero pattern count, the next N cycles are load cycles with `se_o` and `shift_en_o` held at 1 and `cap_en_o` at 0.
- R4: Each time `se_o` falls, exactly max(`settle_i`,1) cycles pass with `se_o`, `shift_en_o` and `cap_en_o` all 0 before the first capture enable. A `settle_i` of 0 counts as 1.
- R5: With `mode_i`=0 (stuck-at), one capture enable is issued per pattern. With `mode_i`=1 (transition), two are issued on consecutive cycles.
- R6: Right after the capture enables, `se_o` returns to 1 for N unload cycles, and the next stimulus loads during those same cycles. The last pattern is followed by an unload-only pass of N cycles.
- R7: During every unload cycle, `scan_out_o` is compared with `exp_i`. A mismatch sets `fail_o` on the following cycle.
- R8: An unload bit with `mask_i`=1 can never cause a failure, whatever the value of `exp_i`.
- R9: `fail_o` stays set until the next accepted start, which clears it. `fail_pat_o` holds the 0-based index of the first pattern that failed.
- R10: `done_o` is high for exactly one cycle when a run ends. A start with `pat_cnt_i`=0 gives `done_o` in the next cycle, with no shift and no capture.
- R11: `start_i` is ignored while `busy_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts a run; accepted only when idle |
| pat_cnt_i | input | PAT_W | Number of patterns in the run |
| mode_i | input | 1 | 0 selects stuck-at (one capture pulse); 1 selects transition (launch and capture) |
| settle_i | input | SET_W | Settle window in cycles; 0 is treated as 1 |
| stim_i | input | 1 | Serial stimulus bit, taken on each shift cycle |
| exp_i | input | 1 | Expected response bit for the current unload cycle |
| mask_i | input | 1 | When 1, the current unload bit is unknown and is not compared |
| se_o | output | 1 | Scan-enable to the chain |
| shift_en_o | output | 1 | Shift clock enable |
| cap_en_o | output | 1 | Capture clock enable |
| scan_out_o | output | 1 | Chain tail bit |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| fail_o | output | 1 | Sticky mismatch flag |
| fail_pat_o | output | PAT_W | Index of the first failing pattern |

## Verification
The assertions assume that `start_i` is the only input able to change the run parameters, and that `rst_ni` is released synchronously with the clock. They also assume that `exp_i` and `mask_i` matter only in unload cycles. The bench holds `pat_cnt_i`, `mode_i` and `settle_i` steady around each accepted start, and it changes every input only on the falling clock edge. It deliberately pulses `start_i` in the middle of a run to show that start has no effect while busy. It also drives random `exp_i` values under the mask to show that masked bits cannot cause a failure.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_SETTLE,
    ST_CAPT,
    ST_UNLOAD,
    ST_FLUSH,
    ST_DONE
  } seq_state_e;
endpackage

// File: rtl/scan_chain.sv
module scan_chain #(
  parameter int N = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic shift_en_i,
  input  logic cap_en_i,
  input  logic scan_in_i,
  output logic scan_out_o
);
  logic [N-1:0] q;

  for (genvar i = 0; i < N; i++) begin : g_cell
    localparam int NXT = (i + 1) % N;
    logic d_scan, d_func;
    if (i == 0) begin : g_head
      assign d_scan = scan_in_i;
    end else begin : g_body
      assign d_scan = q[i-1];
    end
    assign d_func = q[i] ^ q[NXT];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         q[i] <= 1'b0;
      else if (shift_en_i) q[i] <= d_scan;
      else if (cap_en_i)   q[i] <= d_func;
    end
  end

  assign scan_out_o = q[N-1];
endmodule

// File: rtl/scan_fsm.sv
module scan_fsm
  import scan_seq_pkg::*;
#(
  parameter int N     = 16,
  parameter int PAT_W = 8,
  parameter int SET_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [PAT_W-1:0] pat_cnt_i,
  input  logic             mode_i,
  input  logic [SET_W-1:0] settle_i,
  output logic             se_o,
  output logic             shift_en_o,
  output logic             cap_en_o,
  output logic             cmp_en_o,
  output logic             clr_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [PAT_W-1:0] pat_idx_o
);
  localparam int CNT_W = (N > 1) ? $clog2(N) : 1;
  localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(N - 1);

  seq_state_e state_q, state_d;
  logic [CNT_W-1:0] bit_cnt_q;
  logic [SET_W-1:0] wait_cnt_q, settle_q;
  logic [PAT_W-1:0] pat_idx_q, last_pat_q;
  logic             cap_cnt_q, mode_q;
  logic             shifting, bit_last, accept;

  assign shifting = (state_q == ST_LOAD) || (state_q == ST_UNLOAD) || (state_q == ST_FLUSH);
  assign bit_last = bit_cnt_q == BIT_LAST;
  assign accept   = (state_q == ST_IDLE) && start_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start_i) state_d = (pat_cnt_i == '0) ? ST_DONE : ST_LOAD;
      ST_LOAD:   if (bit_last) state_d = ST_SETTLE;
      ST_SETTLE: if (wait_cnt_q == settle_q - SET_W'(1)) state_d = ST_CAPT;
      ST_CAPT:   if (cap_cnt_q == mode_q)
                   state_d = (pat_idx_q == last_pat_q) ? ST_FLUSH : ST_UNLOAD;
      ST_UNLOAD: if (bit_last) state_d = ST_SETTLE;
      ST_FLUSH:  if (bit_last) state_d = ST_DONE;
      ST_DONE:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      bit_cnt_q  <= '0;
      wait_cnt_q <= '0;
      cap_cnt_q  <= 1'b0;
      pat_idx_q  <= '0;
      last_pat_q <= '0;
      settle_q   <= SET_W'(1);
      mode_q     <= 1'b0;
    end else begin
      state_q    <= state_d;
      bit_cnt_q  <= (shifting && !bit_last) ? bit_cnt_q + CNT_W'(1) : '0;
      wait_cnt_q <= (state_q == ST_SETTLE) ? wait_cnt_q + SET_W'(1) : '0;
      cap_cnt_q  <= (state_q == ST_CAPT) ? ~cap_cnt_q : 1'b0;
      if (accept) begin
        pat_idx_q  <= '0;
        last_pat_q <= pat_cnt_i - PAT_W'(1);
        settle_q   <= (settle_i == '0) ? SET_W'(1) : settle_i;
        mode_q     <= mode_i;
      end else if ((state_q == ST_UNLOAD) && bit_last) begin
        pat_idx_q  <= pat_idx_q + PAT_W'(1);
      end
    end
  end

  assign se_o       = shifting;
  assign shift_en_o = shifting;
  assign cap_en_o   = state_q == ST_CAPT;
  assign cmp_en_o   = (state_q == ST_UNLOAD) || (state_q == ST_FLUSH);
  assign clr_o      = accept;
  assign busy_o     = state_q != ST_IDLE;
  assign done_o     = state_q == ST_DONE;
  assign pat_idx_o  = pat_idx_q;
endmodule

// File: rtl/scan_cmp.sv
module scan_cmp #(
  parameter int PAT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             cmp_en_i,
  input  logic             obs_i,
  input  logic             exp_i,
  input  logic             mask_i,
  input  logic [PAT_W-1:0] pat_idx_i,
  output logic             fail_o,
  output logic [PAT_W-1:0] fail_pat_o
);
  logic miss;
  assign miss = cmp_en_i && !mask_i && (obs_i != exp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fail_o     <= 1'b0;
      fail_pat_o <= '0;
    end else if (clr_i) begin
      fail_o     <= 1'b0;
      fail_pat_o <= '0;
    end else if (miss && !fail_o) begin
      fail_o     <= 1'b1;
      fail_pat_o <= pat_idx_i;
    end
  end
endmodule

// File: rtl/scan_seq_top.sv
module scan_seq_top #(
  parameter int N     = 16,
  parameter int PAT_W = 8,
  parameter int SET_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [PAT_W-1:0] pat_cnt_i,
  input  logic             mode_i,
  input  logic [SET_W-1:0] settle_i,
  input  logic             stim_i,
  input  logic             exp_i,
  input  logic             mask_i,
  output logic             se_o,
  output logic             shift_en_o,
  output logic             cap_en_o,
  output logic             scan_out_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             fail_o,
  output logic [PAT_W-1:0] fail_pat_o
);
  logic             cmp_en, clr;
  logic [PAT_W-1:0] pat_idx;

  scan_fsm #(.N(N), .PAT_W(PAT_W), .SET_W(SET_W)) i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .pat_cnt_i  (pat_cnt_i),
    .mode_i     (mode_i),
    .settle_i   (settle_i),
    .se_o       (se_o),
    .shift_en_o (shift_en_o),
    .cap_en_o   (cap_en_o),
    .cmp_en_o   (cmp_en),
    .clr_o      (clr),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .pat_idx_o  (pat_idx)
  );

  scan_chain #(.N(N)) i_chain (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .shift_en_i (shift_en_o),
    .cap_en_i   (cap_en_o),
    .scan_in_i  (stim_i),
    .scan_out_o (scan_out_o)
  );

  scan_cmp #(.PAT_W(PAT_W)) i_cmp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr),
    .cmp_en_i   (cmp_en),
    .obs_i      (scan_out_o),
    .exp_i      (exp_i),
    .mask_i     (mask_i),
    .pat_idx_i  (pat_idx),
    .fail_o     (fail_o),
    .fail_pat_o (fail_pat_o)
  );
endmodule

// File: rtl/scan_seq_chk.sv
module scan_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic se_o,
  input logic shift_en_o,
  input logic cap_en_o,
  input logic busy_o,
  input logic done_o,
  input logic fail_o
);
  p_cap_se_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_en_o |-> !se_o && !shift_en_o);

  p_settle_before_cap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cap_en_o) |-> $past(!se_o && !cap_en_o));

  p_cap_max_two_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_en_o && $past(cap_en_o)) |=> !cap_en_o);

  p_unload_after_cap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cap_en_o) |-> se_o);

  p_fail_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_o && busy_o) |=> fail_o);

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind scan_seq_top scan_seq_chk i_scan_seq_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .se_o       (se_o),
  .shift_en_o (shift_en_o),
  .cap_en_o   (cap_en_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .fail_o     (fail_o)
);

// File: tb/test_scan_seq_top.sv
module test_scan_seq_top;
  localparam int N = 16, PW = 8, SW = 4, ERR_BIT = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, mode = 1'b0, stim = 1'b0, exp_b = 1'b0, mask = 1'b0;
  logic [PW-1:0] pat_cnt = '0;
  logic [SW-1:0] settle = '0;
  logic se, shift_en, cap_en, scan_out, busy, done, fail;
  logic [PW-1:0] fail_pat;

  int checks = 0, failures = 0, cap_seen = 0;
  int err_pat = -1, err_mask = 0;

  // behavioural reference: phase 0 idle,1 load,2 settle,3 capture,4 unload,5 flush,6 done
  int m_phase, m_k, m_w, m_c, m_idx, m_n, m_settle, m_mode, m_fpat;
  logic [N-1:0] m_q, m_nq;
  logic m_fail;

  scan_seq_top #(.N(N), .PAT_W(PW), .SET_W(SW)) i_scan_seq_top (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .pat_cnt_i(pat_cnt),
    .mode_i(mode), .settle_i(settle), .stim_i(stim), .exp_i(exp_b),
    .mask_i(mask), .se_o(se), .shift_en_o(shift_en), .cap_en_o(cap_en),
    .scan_out_o(scan_out), .busy_o(busy), .done_o(done), .fail_o(fail),
    .fail_pat_o(fail_pat)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", req, act, expv);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_k = 0; m_w = 0; m_c = 0; m_idx = 0; m_n = 0;
      m_settle = 1; m_mode = 0; m_q = '0; m_fail = 1'b0; m_fpat = 0;
    end else begin
      case (m_phase)
        0: if (start) begin
             m_fail = 1'b0; m_fpat = 0;
             if (pat_cnt == 0) m_phase = 6;
             else begin
               m_phase = 1; m_k = 0; m_idx = 0; m_n = pat_cnt;
               m_mode = mode; m_settle = (settle == 0) ? 1 : settle;
             end
           end
        1: begin
             m_q = {m_q[N-2:0], stim}; m_k++;
             if (m_k == N) begin m_phase = 2; m_w = 0; end
           end
        2: begin
             m_w++;
             if (m_w == m_settle) begin m_phase = 3; m_c = 0; end
           end
        3: begin
             for (int i = 0; i < N; i++) m_nq[i] = m_q[i] ^ m_q[(i+1)%N];
             m_q = m_nq; m_c++;
             if (m_c == (m_mode ? 2 : 1)) begin
               m_phase = (m_idx == m_n - 1) ? 5 : 4; m_k = 0;
             end
           end
        4, 5: begin
             if (!mask && exp_b != m_q[N-1] && !m_fail) begin m_fail = 1'b1; m_fpat = m_idx; end
             m_q = {m_q[N-2:0], stim}; m_k++;
             if (m_k == N) begin
               if (m_phase == 4) begin m_idx++; m_phase = 2; m_w = 0; end
               else m_phase = 6;
             end
           end
        default: m_phase = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R3/R6 se_o", se, (m_phase == 1 || m_phase >= 4 && m_phase <= 5) ? 1 : 0);
      chk("R1 shift_en_o", shift_en, (m_phase == 1 || m_phase == 4 || m_phase == 5) ? 1 : 0);
      chk("R4/R5 cap_en_o", cap_en, (m_phase == 3) ? 1 : 0);
      chk("R1/R2 scan_out_o", scan_out, m_q[N-1]);
      chk("R11 busy_o", busy, (m_phase != 0) ? 1 : 0);
      chk("R10 done_o", done, (m_phase == 6) ? 1 : 0);
      chk("R7/R9 fail_o", fail, m_fail);
      if (m_fail) chk("R9 fail_pat_o", fail_pat, m_fpat);
      if (cap_en) cap_seen++;
    end
    stim = 1'($urandom);
    exp_b = m_q[N-1];
    mask = 1'b0;
    if ((m_phase == 4 || m_phase == 5) && m_idx == err_pat && m_k == ERR_BIT) begin
      exp_b = ~exp_b; mask = 1'(err_mask);
    end else if ($urandom % 4 == 0) begin
      mask = 1'b1; exp_b = 1'($urandom);   // R8: random expected under mask
    end
  end

  task automatic run(input int cnt, input int md, input int st,
                     input int epat, input int emask, input bit poke);
    err_pat = epat; err_mask = emask; cap_seen = 0;
    @(negedge clk);
    pat_cnt = PW'(cnt); mode = md[0]; settle = SW'(st); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (5) @(negedge clk);
      start = 1'b1; pat_cnt = PW'(3); mode = ~mode;   // R11: ignored while busy
      @(negedge clk);
      start = 1'b0;
    end
    while (m_phase != 0) @(negedge clk);
    chk("R5/R11 capture pulse count", cap_seen, cnt * (md ? 2 : 1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R3 reset se_o", se, 0);
    chk("R4 reset cap_en_o", cap_en, 0);
    chk("R10 reset done_o", done, 0);
    chk("R9 reset fail_o", fail, 0);
    rst_n = 1'b1;

    run(3, 0, 2, -1, 0, 1'b0);
    chk("R7 clean stuck-at run", fail, 0);
    run(2, 1, 0, 1, 1, 1'b1);
    chk("R8 masked mismatch ignored", fail, 0);
    run(4, 1, 5, 2, 0, 1'b0);
    chk("R9 fail flag", fail, 1);
    chk("R9 first failing pattern", fail_pat, 2);
    run(0, 0, 1, -1, 0, 1'b0);
    chk("R9 start clears fail", fail, 0);
    chk("R10 zero-count run no capture", cap_seen, 0);
    run(2, 0, 15, 0, 0, 1'b1);
    chk("R7 mismatch in pattern 0", fail, 1);
    chk("R9 first failing pattern 0", fail_pat, 0);
    run(1, 1, 1, -1, 0, 1'b0);
    chk("R6 single pattern flush", fail, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R10 act=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule